// File: doc/BRIEF.md
# Slow Lane Instruction Queue

This block is an in-order side buffer for instructions that wait on long-latency loads, the ones that miss the second-level cache. Instructions arrive one per cycle, in program order, from a small retirement window ahead of the block. An instruction whose sources do not wait on any outstanding miss goes on to the issue queue in the same cycle. An instruction with a source that waits on a miss is appended to the slow lane instead, so it does not take an issue-queue slot for hundreds of cycles.

The block keeps one wait ("poison") bit for each physical register. A missing load poisons its destination. A parked instruction passes the poison on to its own destination, so that whole dependence chains end up in the lane. When a missing load arrives at the block, the block returns the lane's current tail position. The surrounding logic stores that position with the load and hands it back when the load completes. On completion the block clears the load's poison and walks the lane from the returned position towards the tail. It reinserts every valid entry whose sources are now clean into the issue queue, at most one per cycle. A completion at a position older than the walk in progress restarts the walk there.

Positions are the entry index with one extra wrap bit. Age is measured relative to the lane head. The depth must be a power of two.

Top module: `slowlane_q`

## Requirements
- R1: An accepted instruction with no enabled source that is poisoned is sent on in the same cycle: `fwd_valid` is high and `fwd_op` equals `in_op`. The instruction is not stored in the lane.
- R2: While `in_miss` is high, `miss_pos` equals the tail position: the number of entries ever appended, modulo twice the depth. The load itself is forwarded, and its destination becomes poisoned from the next cycle on.
- R3: An accepted instruction with an enabled source (A or B) that is poisoned is appended at the tail and is not forwarded. Its enabled destination becomes poisoned.
- R4: A completion (`done_valid`, `done_pos`, `done_dst`) clears the poison of `done_dst`. The walk starts at `done_pos` in the next cycle. Each valid entry whose enabled sources are clean is presented on `ri_valid`/`ri_op`, in lane order, one per cycle, and is then removed.
- R5: The walk steps over an entry that is still poisoned by another outstanding load, and the entry stays in the lane. It is reinserted on a later walk.
- R6: Reinsertion clears the poison of the entry's destination. A dependent further along the lane is therefore reinserted in the same walk.
- R7: While `iq_full` is high, `ri_valid` stays low and the walk holds at the eligible entry. The entry is presented once `iq_full` falls.
- R8: When the lane holds DEPTH entries, `in_ready` is low for an instruction that would be parked. An instruction with clean sources is still accepted and forwarded.
- R9: A completion whose position is no younger than the current walk position restarts the walk at that position. A completion at a younger position leaves the walk running.
- R10: Reset empties the lane, stops the walk and clears every poison bit.
- R11: The walk ends when it reaches the tail. No reinsertion is presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction leaving the retirement window |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_op | input | OP_W | Opaque instruction payload |
| in_src_a | input | PTAG_W | Source A physical tag |
| in_src_a_en | input | 1 | Source A is used |
| in_src_b | input | PTAG_W | Source B physical tag |
| in_src_b_en | input | 1 | Source B is used |
| in_dst | input | PTAG_W | Destination physical tag |
| in_dst_en | input | 1 | Destination is written |
| in_miss | input | 1 | Instruction is a load that missed |
| miss_pos | output | IDX_W+1 | Lane position to record with a missing load |
| fwd_valid | output | 1 | Instruction forwarded to the issue queue |
| fwd_op | output | OP_W | Forwarded payload |
| iq_full | input | 1 | Issue queue cannot take a reinsertion |
| ri_valid | output | 1 | Parked instruction reinserted this cycle |
| ri_op | output | OP_W | Reinserted payload |
| done_valid | input | 1 | A missing load completed |
| done_pos | input | IDX_W+1 | Position recorded for that load |
| done_dst | input | PTAG_W | Destination tag of that load |

## Verification
The bench builds the lane with DEPTH of 4, PTAG_W of 4 and OP_W of 8. The shallow lane lets a short run fill it completely, so back-pressure comes into play. The run also carries the tail past the index range, which exercises the wrap bit in the age comparisons. The bench replays a chain in which one parked entry depends on another, walks past an entry still held by a second load, stalls a reinsertion with `iq_full`, and restarts a walk from an older position after a younger completion.

// File: rtl/slq_pkg.sv
package slq_pkg;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } walk_st_e;

    // Distance of position p from head h, modulo 2**w (w <= 16).
    function automatic logic [15:0] pos_age(input logic [15:0] p,
                                            input logic [15:0] h,
                                            input int          w);
        logic [15:0] m;
        m = (16'd1 << w) - 16'd1;
        return (p - h) & m;
    endfunction

endpackage

// File: rtl/slq_poison.sv
module slq_poison #(
    parameter int TW  = 6,
    parameter int NRD = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr0_en,
    input  logic [TW-1:0]           clr0_tag,
    input  logic                    clr1_en,
    input  logic [TW-1:0]           clr1_tag,
    input  logic                    set_en,
    input  logic [TW-1:0]           set_tag,
    input  logic                    set_val,
    input  logic [NRD-1:0][TW-1:0]  rd_tag,
    output logic [NRD-1:0]          rd_hit
);
    localparam int NREG = 1 << TW;

    logic [NREG-1:0] bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= '0;
        end else begin
            if (clr0_en) bits[clr0_tag] <= 1'b0;
            if (clr1_en) bits[clr1_tag] <= 1'b0;
            if (set_en)  bits[set_tag]  <= set_val;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_hit[g] = bits[rd_tag[g]];
    end
endmodule

// File: rtl/slq_store.sv
module slq_store #(
    parameter  int W     = 16,
    parameter  int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int POS_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             kill,
    input  logic [POS_W-1:0] kill_pos,
    input  logic [POS_W-1:0] rd_pos,
    input  logic             hold_head,
    output logic [W-1:0]     rd_data,
    output logic             rd_vld,
    output logic [POS_W-1:0] head,
    output logic [POS_W-1:0] tail,
    output logic [POS_W-1:0] occ
);
    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] vld;
    logic             head_adv;

    assign occ      = tail - head;
    assign rd_data  = mem[rd_pos[IDX_W-1:0]];
    assign rd_vld   = vld[rd_pos[IDX_W-1:0]];
    assign head_adv = (head != tail) && !vld[head[IDX_W-1:0]] && !hold_head;

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            vld  <= '0;
        end else begin
            if (push) begin
                vld[tail[IDX_W-1:0]] <= 1'b1;
                tail <= tail + 1'b1;
            end
            if (kill)     vld[kill_pos[IDX_W-1:0]] <= 1'b0;
            if (head_adv) head <= head + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[tail[IDX_W-1:0]] <= push_data;
    end
endmodule

// File: rtl/slq_walk.sv
module slq_walk
    import slq_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [POS_W-1:0] start_pos,
    input  logic [POS_W-1:0] head,
    input  logic [POS_W-1:0] tail,
    input  logic             step,
    output logic [POS_W-1:0] ptr,
    output logic             walking
);
    walk_st_e    st;
    logic [15:0] a_start, a_tail, a_ptr, a_ent;
    logic [POS_W-1:0] entry;
    logic        begin_now;

    always_comb begin
        a_start = pos_age(16'(start_pos), 16'(head), POS_W);
        a_tail  = pos_age(16'(tail), 16'(head), POS_W);
        a_ptr   = pos_age(16'(ptr), 16'(head), POS_W);
        // A position already behind the head starts at the head.
        if (a_start > a_tail) begin
            entry = head;
            a_ent = '0;
        end else begin
            entry = start_pos;
            a_ent = a_start;
        end
        begin_now = start && ((st == WK_IDLE) || (a_ent <= a_ptr));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= WK_IDLE;
            ptr <= '0;
        end else if (begin_now) begin
            st  <= WK_RUN;
            ptr <= entry;
        end else if (st == WK_RUN) begin
            if (ptr == tail)   st  <= WK_IDLE;
            else if (step)     ptr <= ptr + 1'b1;
        end
    end

    assign walking = (st == WK_RUN);
endmodule

// File: rtl/slowlane_q.sv
module slowlane_q #(
    parameter  int PTAG_W = 6,
    parameter  int DEPTH  = 32,
    parameter  int OP_W   = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int POS_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [PTAG_W-1:0] in_src_a,
    input  logic              in_src_a_en,
    input  logic [PTAG_W-1:0] in_src_b,
    input  logic              in_src_b_en,
    input  logic [PTAG_W-1:0] in_dst,
    input  logic              in_dst_en,
    input  logic              in_miss,
    output logic [POS_W-1:0]  miss_pos,
    output logic              fwd_valid,
    output logic [OP_W-1:0]   fwd_op,
    input  logic              iq_full,
    output logic              ri_valid,
    output logic [OP_W-1:0]   ri_op,
    input  logic              done_valid,
    input  logic [POS_W-1:0]  done_pos,
    input  logic [PTAG_W-1:0] done_dst
);
    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [PTAG_W-1:0] sa;
        logic              sa_en;
        logic [PTAG_W-1:0] sb;
        logic              sb_en;
        logic [PTAG_W-1:0] dst;
        logic              dst_en;
    } ent_t;
    localparam int ENT_W = $bits(ent_t);

    ent_t                   in_ent, wk_ent;
    logic [ENT_W-1:0]       wk_bits;
    logic                   wk_vld;
    logic [3:0][PTAG_W-1:0] rd_tag;
    logic [3:0]             rd_hit;
    logic [POS_W-1:0]       head, tail, occ, wk_ptr;
    logic                   walking, full, park_need, accept, push;
    logic                   examine, eligible, step, hold_head;

    assign in_ent = '{op: in_op, sa: in_src_a, sa_en: in_src_a_en,
                      sb: in_src_b, sb_en: in_src_b_en,
                      dst: in_dst, dst_en: in_dst_en};
    assign wk_ent = ent_t'(wk_bits);

    assign rd_tag[0] = in_src_a;
    assign rd_tag[1] = in_src_b;
    assign rd_tag[2] = wk_ent.sa;
    assign rd_tag[3] = wk_ent.sb;

    // Ingress: park on any poisoned source, otherwise forward.
    assign full      = (occ == POS_W'(DEPTH));
    assign park_need = (in_src_a_en && rd_hit[0]) || (in_src_b_en && rd_hit[1]);
    assign in_ready  = !(park_need && full);
    assign accept    = in_valid && in_ready;
    assign push      = accept && park_need;
    assign fwd_valid = accept && !park_need;
    assign fwd_op    = in_op;
    assign miss_pos  = tail;

    // Walk: reinsert clean entries, hold while the issue queue is full.
    assign examine   = walking && (wk_ptr != tail);
    assign eligible  = examine && wk_vld &&
                       !((wk_ent.sa_en && rd_hit[2]) || (wk_ent.sb_en && rd_hit[3]));
    assign ri_valid  = eligible && !iq_full;
    assign ri_op     = wk_ent.op;
    assign step      = examine && !(eligible && iq_full);
    assign hold_head = done_valid || (walking && (wk_ptr == head));

    slq_poison #(.TW(PTAG_W), .NRD(4)) u_poison (
        .clk      (clk),
        .rst      (rst),
        .clr0_en  (done_valid),
        .clr0_tag (done_dst),
        .clr1_en  (ri_valid && wk_ent.dst_en),
        .clr1_tag (wk_ent.dst),
        .set_en   (accept && in_dst_en),
        .set_tag  (in_dst),
        .set_val  (park_need || in_miss),
        .rd_tag   (rd_tag),
        .rd_hit   (rd_hit)
    );

    slq_store #(.W(ENT_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (in_ent),
        .kill      (ri_valid),
        .kill_pos  (wk_ptr),
        .rd_pos    (wk_ptr),
        .hold_head (hold_head),
        .rd_data   (wk_bits),
        .rd_vld    (wk_vld),
        .head      (head),
        .tail      (tail),
        .occ       (occ)
    );

    slq_walk #(.POS_W(POS_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .start     (done_valid),
        .start_pos (done_pos),
        .head      (head),
        .tail      (tail),
        .step      (step),
        .ptr       (wk_ptr),
        .walking   (walking)
    );
endmodule

// File: rtl/slq_chk.sv
module slq_chk #(
    parameter int POS_W = 6,
    parameter int DEPTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             fwd_valid,
    input logic             ri_valid,
    input logic             iq_full,
    input logic             walking,
    input logic [POS_W-1:0] occ
);
    AST_RI_HELD_FULL: assert property (@(posedge clk) disable iff (rst)
        ri_valid |-> !iq_full);                                   // R7
    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst)
        occ <= POS_W'(DEPTH));                                    // R8
    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |-> (occ == POS_W'(DEPTH)));      // R8
    AST_FWD_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (in_valid && in_ready));                    // R1
    AST_RI_IN_WALK: assert property (@(posedge clk) disable iff (rst)
        ri_valid |-> walking);                                    // R4
endmodule

bind slowlane_q slq_chk #(.POS_W(POS_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .fwd_valid (fwd_valid),
    .ri_valid  (ri_valid),
    .iq_full   (iq_full),
    .walking   (walking),
    .occ       (occ)
);

// File: tb/sim_slowlane_q.sv
`timescale 1ns/1ps
module sim_slowlane_q;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_ready, in_src_a_en, in_src_b_en, in_dst_en, in_miss;
    logic [7:0] in_op, fwd_op, ri_op;
    logic [3:0] in_src_a, in_src_b, in_dst, done_dst;
    logic [2:0] miss_pos, done_pos;
    logic       fwd_valid, iq_full, ri_valid, done_valid;
    int         errs = 0;
    int         checks = 0;

    always #10 clk = ~clk;

    slowlane_q #(.PTAG_W(4), .DEPTH(4), .OP_W(8)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
        .in_src_b(in_src_b), .in_src_b_en(in_src_b_en), .in_dst(in_dst),
        .in_dst_en(in_dst_en), .in_miss(in_miss), .miss_pos(miss_pos),
        .fwd_valid(fwd_valid), .fwd_op(fwd_op), .iq_full(iq_full),
        .ri_valid(ri_valid), .ri_op(ri_op), .done_valid(done_valid),
        .done_pos(done_pos), .done_dst(done_dst)
    );

    typedef struct packed {
        logic       iv;
        logic [7:0] op;
        logic [3:0] sa;
        logic       sae;
        logic [3:0] sb;
        logic       sbe;
        logic [3:0] dst;
        logic       de;
        logic       miss;
        logic       dv;
        logic [2:0] dpos;
        logic [3:0] ddst;
        logic       full;
        logic       efv;
        logic [7:0] efop;
        logic       erv;
        logic [7:0] erop;
        logic       erdy;
        logic [2:0] epos;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1,8'h10, 0,0, 0,0,  1,1,1, 0,0, 0,0, 1,8'h10, 0,8'h00, 1,0,  2}, // R2 miss A, pos 0
        '{1,8'h21, 1,1, 0,0,  2,1,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0,  3}, // R3 park on src 1
        '{1,8'h32, 3,1, 0,0,  4,1,0, 0,0, 0,0, 1,8'h32, 0,8'h00, 1,0,  1}, // R1 clean, forward
        '{1,8'h43, 0,0, 0,0,  5,1,1, 0,0, 0,0, 1,8'h43, 0,8'h00, 1,1,  2}, // R2 miss B, pos 1
        '{1,8'h54, 5,1, 0,0,  6,1,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0,  3}, // R3 park on src 5
        '{1,8'h65, 3,1, 2,1,  7,1,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0,  3}, // R3 park via src B
        '{0,8'h00, 0,0, 0,0,  0,0,0, 1,0, 1,0, 0,8'h00, 0,8'h00, 1,0,  4}, // R4 done A at pos 0
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 1,8'h21, 1,0,  4}, // R4 reinsert 21
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0,  5}, // R5 skip 54
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 1,8'h65, 1,0,  6}, // R6 chained 65
        '{1,8'h76, 6,1, 0,0,  8,1,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0, 11}, // R11 tail, park 76
        '{1,8'h87, 8,1, 0,0,  9,1,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0,  3}, // R3 park 87, full
        '{1,8'h98, 9,1, 0,0, 10,1,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 0,0,  8}, // R8 stall when full
        '{1,8'hA9, 3,1, 0,0, 11,1,0, 0,0, 0,0, 1,8'hA9, 0,8'h00, 1,0,  8}, // R8 clean passes
        '{0,8'h00, 0,0, 0,0,  0,0,0, 1,1, 5,1, 0,8'h00, 0,8'h00, 1,0,  7}, // R7 done B, iq full
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,1, 0,8'h00, 0,8'h00, 1,0,  7}, // R7 held
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 1,8'h54, 1,0,  7}, // R7 released 54
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0,  4}, // R4 removed entry
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 1,8'h76, 1,0,  6}, // R6 chained 76
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 1,8'h87, 1,0,  6}, // R6 chained 87
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0, 11}, // R11 stop at tail
        '{1,8'hB0, 0,0, 0,0, 12,1,1, 0,0, 0,0, 1,8'hB0, 0,8'h00, 1,5,  2}, // R2 pos wraps to 5
        '{1,8'hB1,12,1, 0,0, 13,1,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0,  3}, // R3 park B1
        '{1,8'hB2, 0,0, 0,0, 14,1,1, 0,0, 0,0, 1,8'hB2, 0,8'h00, 1,6,  2}, // R2 pos 6
        '{1,8'hB3,14,1, 0,0, 15,1,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0,  3}, // R3 park B3
        '{0,8'h00, 0,0, 0,0,  0,0,0, 1,6,14,0, 0,8'h00, 0,8'h00, 1,0,  9}, // R9 younger done
        '{0,8'h00, 0,0, 0,0,  0,0,0, 1,5,12,0, 0,8'h00, 1,8'hB3, 1,0,  9}, // R9 older done
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 1,8'hB1, 1,0,  9}, // R9 restarted
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0,  9}, // R9 removed
        '{0,8'h00, 0,0, 0,0,  0,0,0, 0,0, 0,0, 0,8'h00, 0,8'h00, 1,0, 11}  // R11 at tail
    };

    task automatic chk(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid = v.iv;  in_op = v.op;
        in_src_a = v.sa;  in_src_a_en = v.sae;
        in_src_b = v.sb;  in_src_b_en = v.sbe;
        in_dst = v.dst;   in_dst_en = v.de;  in_miss = v.miss;
        done_valid = v.dv; done_pos = v.dpos; done_dst = v.ddst;
        iq_full = v.full;
    endtask

    task automatic check_vec(input vec_t v, input int i);
        chk(v.req, $sformatf("row %0d in_ready", i), in_ready, v.erdy);
        chk(v.req, $sformatf("row %0d fwd_valid", i), fwd_valid, v.efv);
        if (v.efv) chk(v.req, $sformatf("row %0d fwd_op", i), fwd_op, v.efop);
        chk(v.req, $sformatf("row %0d ri_valid", i), ri_valid, v.erv);
        if (v.erv) chk(v.req, $sformatf("row %0d ri_op", i), ri_op, v.erop);
        if (v.iv && v.miss) chk(v.req, $sformatf("row %0d miss_pos", i), miss_pos, v.epos);
    endtask

    localparam vec_t IDLE = '0;

    initial begin
        #(20 * 20000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        vec_t v;
        rst = 1'b1;
        drive(IDLE);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R10 reset state
        chk(10, "reset in_ready", in_ready, 1);
        chk(10, "reset fwd_valid", fwd_valid, 0);
        chk(10, "reset ri_valid", ri_valid, 0);
        chk(10, "reset miss_pos", miss_pos, 0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            #2;
            check_vec(VEC[i], i);
            @(negedge clk);
        end

        // R2 miss at tail 7, then R10 reset mid-run must clear its poison
        v = IDLE; v.iv = 1; v.op = 8'hC0; v.dst = 3; v.de = 1; v.miss = 1;
        drive(v);
        #2;
        chk(2, "pre-reset miss_pos", miss_pos, 7);
        @(negedge clk);
        drive(IDLE);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk(10, "post-reset ri_valid", ri_valid, 0);
        v = IDLE; v.iv = 1; v.op = 8'hC1; v.sa = 3; v.sae = 1; v.dst = 4; v.de = 1;
        drive(v);
        #2;
        chk(10, "post-reset poison cleared fwd_valid", fwd_valid, 1);
        chk(10, "post-reset fwd_op", fwd_op, 8'hC1);
        @(negedge clk);
        v = IDLE; v.iv = 1; v.op = 8'hC2; v.dst = 5; v.de = 1; v.miss = 1;
        drive(v);
        #2;
        chk(10, "post-reset lane empty miss_pos", miss_pos, 0);
        @(negedge clk);
        drive(IDLE);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule